// File: doc/BRIEF.md
# Ripple-Carry Bit-Slice ALU

This block is a purely combinational integer arithmetic-logic unit. It is assembled from a chain of one-bit slices, and every slice has the same structure. Each slice forms the bitwise AND and the bitwise OR of its two operand bits. It also has a full adder whose B input can be complemented. A four-way selector then picks the slice's result bit. The carry ripples upward from the lowest slice to the highest. There is no lookahead.

The unit supports five functions: AND, OR, add, subtract and set-on-less-than. The caller picks a function with a 2-bit operation code and one subtract line. The subtract line does two jobs at once: it complements the B operand and it supplies the carry into bit 0. The topmost slice differs from the others. It also brings out its raw adder sum, and the set-on-less-than path feeds that sum into the "less" input of bit 0. The topmost slice also flags signed overflow. A zero flag over the whole result allows equality tests to be built on a subtraction.

Top module: `ripple_alu`

## Requirements
- R1: With op_i = 2'b00, res_o equals opa_i AND opb_i, bit by bit.
- R2: With op_i = 2'b01, res_o equals opa_i OR opb_i, bit by bit.
- R3: With op_i = 2'b10 and sub_i = 0, res_o equals (opa_i + opb_i) modulo 2^WIDTH.
- R4: With op_i = 2'b10 and sub_i = 1, res_o equals opa_i + ~opb_i + 1 modulo 2^WIDTH, which is opa_i - opb_i.
- R5: With op_i = 2'b11 and sub_i = 1, res_o bits WIDTH-1..1 are 0. Bit 0 equals the top bit of the unadjusted sum opa_i + ~opb_i + 1, even when that subtraction overflows.
- R6: ovf_o equals the carry into the top slice XOR the carry out of the top slice, for every operation code.
- R7: zero_o is 1 exactly when every bit of res_o is 0.
- R8: cout_o is the carry out of the top slice of opa_i + (sub_i ? ~opb_i : opb_i) + sub_i, for every operation code, logic ones included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand (complemented when sub_i is 1) |
| op_i | input | 2 | Result select: 00 AND, 01 OR, 10 adder, 11 less |
| sub_i | input | 1 | Complements B and sets the bit-0 carry-in |
| res_o | output | WIDTH | Selected result |
| cout_o | output | 1 | Carry out of the top slice |
| ovf_o | output | 1 | Signed overflow of the adder chain |
| zero_o | output | 1 | Result is all zeros |

## Verification
The bench builds two copies of the unit. One uses the default WIDTH of 32. The other uses WIDTH = 4, which is small enough that every operand pair can be driven under all five defined functions. That exhaustive sweep covers every carry pattern, every overflow case and every set-on-less-than result that overflows, which random operands at 32 bits would rarely reach. The 32-bit copy is driven with directed corner operands, such as the extreme signed values, all-ones, and equal operands. It also gets random operands, so the full-length carry chain and the zero flag are exercised as well.

// File: rtl/alu_pkg.sv
package alu_pkg;

   // Result select codes; the slice multiplexer decodes them directly.
   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } alu_sel_e;

   // One-bit full adder, sum part.
   function automatic logic fa_sum(input logic x, input logic y, input logic ci);
      return x ^ y ^ ci;
   endfunction

   // One-bit full adder, carry part.
   function automatic logic fa_carry(input logic x, input logic y, input logic ci);
      return (x & y) | (x & ci) | (y & ci);
   endfunction

   // Four-way result pick shared by every slice variant.
   function automatic logic pick(input alu_sel_e s, input logic an, input logic orr,
                                 input logic sm, input logic lt);
      logic r;
      case (s)
         SEL_AND:  r = an;
         SEL_OR:   r = orr;
         SEL_SUM:  r = sm;
         default:  r = lt;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/alu_slice.sv
// Ordinary one-bit slice used for every bit below the top.
module alu_slice
   import alu_pkg::*;
(
   input  logic     a_i,
   input  logic     b_i,
   input  logic     binv_i,
   input  logic     ci_i,
   input  logic     less_i,
   input  alu_sel_e sel_i,
   output logic     r_o,
   output logic     co_o
);
   logic b_eff;
   logic s_bit;

   always_comb begin
      b_eff = b_i ^ binv_i;
      s_bit = fa_sum(a_i, b_eff, ci_i);
      co_o  = fa_carry(a_i, b_eff, ci_i);
      r_o   = pick(sel_i, a_i & b_i, a_i | b_i, s_bit, less_i);
   end
endmodule

// File: rtl/alu_slice_msb.sv
// Top slice: the same datapath, plus the raw sum and the overflow flag.
module alu_slice_msb
   import alu_pkg::*;
(
   input  logic     a_i,
   input  logic     b_i,
   input  logic     binv_i,
   input  logic     ci_i,
   input  logic     less_i,
   input  alu_sel_e sel_i,
   output logic     r_o,
   output logic     co_o,
   output logic     set_o,
   output logic     ovf_o
);
   logic b_eff;
   logic s_bit;

   always_comb begin
      b_eff = b_i ^ binv_i;
      s_bit = fa_sum(a_i, b_eff, ci_i);
      co_o  = fa_carry(a_i, b_eff, ci_i);
      r_o   = pick(sel_i, a_i & b_i, a_i | b_i, s_bit, less_i);
      set_o = s_bit;
      ovf_o = ci_i ^ co_o;
   end
endmodule

// File: rtl/alu_zero_detect.sv
// Zero detection, built as a tree of OR reductions over groups of GROUP bits.
module alu_zero_detect #(
   parameter int WIDTH = 32,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] v_i,
   output logic             zero_o
);
   localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
   localparam int PADW = NGRP * GROUP;

   if (GROUP < 1) begin : g_bad_group
      $error("alu_zero_detect: GROUP must be at least 1");
   end

   logic [PADW-1:0] padded;
   logic [NGRP-1:0] grp_any;

   if (PADW > WIDTH) begin : g_pad
      assign padded = {{(PADW-WIDTH){1'b0}}, v_i};
   end else begin : g_nopad
      assign padded = v_i;
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_any[g] = |padded[g*GROUP +: GROUP];
   end

   assign zero_o = ~|grp_any;
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
   import alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ZERO_GROUP = 4
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic [1:0]       op_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o,
   output logic             ovf_o,
   output logic             zero_o
);
   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("ripple_alu: WIDTH must be at least 2");
   end
   if (ZERO_GROUP < 1 || ZERO_GROUP > WIDTH) begin : g_bad_zgrp
      $error("ripple_alu: ZERO_GROUP must lie in 1..WIDTH");
   end

   alu_sel_e         sel;
   logic [WIDTH:0]   carry;
   logic             set_msb;

   assign sel      = alu_sel_e'(op_i);
   assign carry[0] = sub_i;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == TOP) begin : g_msb
         alu_slice_msb u_slice (
            .a_i    (opa_i[i]),
            .b_i    (opb_i[i]),
            .binv_i (sub_i),
            .ci_i   (carry[i]),
            .less_i (1'b0),
            .sel_i  (sel),
            .r_o    (res_o[i]),
            .co_o   (carry[i+1]),
            .set_o  (set_msb),
            .ovf_o  (ovf_o)
         );
      end else if (i == 0) begin : g_lsb
         alu_slice u_slice (
            .a_i    (opa_i[i]),
            .b_i    (opb_i[i]),
            .binv_i (sub_i),
            .ci_i   (carry[i]),
            .less_i (set_msb),
            .sel_i  (sel),
            .r_o    (res_o[i]),
            .co_o   (carry[i+1])
         );
      end else begin : g_mid
         alu_slice u_slice (
            .a_i    (opa_i[i]),
            .b_i    (opb_i[i]),
            .binv_i (sub_i),
            .ci_i   (carry[i]),
            .less_i (1'b0),
            .sel_i  (sel),
            .r_o    (res_o[i]),
            .co_o   (carry[i+1])
         );
      end
   end

   assign cout_o = carry[WIDTH];

   alu_zero_detect #(
      .WIDTH (WIDTH),
      .GROUP (ZERO_GROUP)
   ) u_zero (
      .v_i    (res_o),
      .zero_o (zero_o)
   );
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk #(
   parameter int W = 32
) (
   input logic [W-1:0] opa_i,
   input logic [W-1:0] opb_i,
   input logic [1:0]   op_i,
   input logic         sub_i,
   input logic [W-1:0] res_o,
   input logic         cout_o,
   input logic         ovf_o,
   input logic         zero_o
);
   logic [W:0]   wide_sum;
   logic [W-1:0] b_used;
   logic         top_ci;
   logic [W-1:0] low_sum;

   always_comb begin
      b_used   = sub_i ? ~opb_i : opb_i;
      wide_sum = {1'b0, opa_i} + {1'b0, b_used} + {{W{1'b0}}, sub_i};
      low_sum  = {1'b0, opa_i[W-2:0]} + {1'b0, b_used[W-2:0]} + {{(W-1){1'b0}}, sub_i};
      top_ci   = low_sum[W-1];
      // R1
      and_result_chk: assert (op_i != 2'b00 || res_o == (opa_i & opb_i))
         else $error("R1 AND result mismatch");
      // R2
      or_result_chk: assert (op_i != 2'b01 || res_o == (opa_i | opb_i))
         else $error("R2 OR result mismatch");
      // R3 and R4
      sum_result_chk: assert (op_i != 2'b10 || res_o == wide_sum[W-1:0])
         else $error("R3/R4 adder result mismatch");
      // R5
      less_result_chk: assert (!(op_i == 2'b11 && sub_i) ||
                               res_o == {{(W-1){1'b0}}, wide_sum[W-1]})
         else $error("R5 less result mismatch");
      // R6
      no_overflow_chk: assert (ovf_o == (top_ci ^ wide_sum[W]))
         else $error("R6 overflow mismatch");
      // R7
      zero_flag_chk: assert (zero_o == (res_o == '0))
         else $error("R7 zero flag mismatch");
      // R8
      carry_out_chk: assert (cout_o == wide_sum[W])
         else $error("R8 carry out mismatch");
   end
endmodule

bind ripple_alu ripple_alu_chk #(.W(WIDTH)) u_chk (
   .opa_i  (opa_i),
   .opb_i  (opb_i),
   .op_i   (op_i),
   .sub_i  (sub_i),
   .res_o  (res_o),
   .cout_o (cout_o),
   .ovf_o  (ovf_o),
   .zero_o (zero_o)
);

// File: tb/ripple_alu_test.sv
module ripple_alu_test;
   localparam int CLK_PERIOD = 10;
   localparam int WN = 4;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [31:0] a32, b32, r32;
   logic [1:0]  op32;
   logic        s32, co32, ov32, z32;

   logic [WN-1:0] an, bn, rn;
   logic [1:0]    opn;
   logic          sn, con, ovn, zn;

   ripple_alu #(.WIDTH(32)) uut (
      .opa_i(a32), .opb_i(b32), .op_i(op32), .sub_i(s32),
      .res_o(r32), .cout_o(co32), .ovf_o(ov32), .zero_o(z32)
   );

   ripple_alu #(.WIDTH(WN), .ZERO_GROUP(2)) uut_narrow (
      .opa_i(an), .opb_i(bn), .op_i(opn), .sub_i(sn),
      .res_o(rn), .cout_o(con), .ovf_o(ovn), .zero_o(zn)
   );

   // Behavioural reference computed from the requirements.
   task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                        input logic sub, input int w, output logic [31:0] r,
                        output logic co, output logic ov, output logic z);
      logic [32:0] mask, lmask, bb, s, ls;
      mask  = (33'd1 << w) - 33'd1;
      lmask = (33'd1 << (w-1)) - 33'd1;
      bb    = {1'b0, (sub ? ~b : b)} & mask;
      s     = ({1'b0, a} & mask) + bb + {32'd0, sub};
      ls    = (({1'b0, a} & lmask) + (bb & lmask) + {32'd0, sub}) >> (w-1);
      co    = s[w];
      ov    = ls[0] ^ co;
      case (op)
         2'b00:   r = a & b & mask[31:0];
         2'b01:   r = (a | b) & mask[31:0];
         2'b10:   r = s[31:0] & mask[31:0];
         default: r = {31'd0, s[w-1]};
      endcase
      z = (r == 32'd0);
   endtask

   function automatic string rtag(input logic [1:0] op, input logic sub);
      case (op)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return sub ? "R4" : "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply32(input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] op, input logic sub);
      logic [31:0] er;
      logic eco, eov, ez;
      @(negedge clk);
      a32 = a; b32 = b; op32 = op; s32 = sub;
      #1;
      model(a, b, op, sub, 32, er, eco, eov, ez);
      cmp(rtag(op, sub), r32, er);
      cmp("R8", {31'd0, co32}, {31'd0, eco});
      cmp("R6", {31'd0, ov32}, {31'd0, eov});
      cmp("R7", {31'd0, z32}, {31'd0, ez});
   endtask

   task automatic apply_n(input logic [WN-1:0] a, input logic [WN-1:0] b,
                          input logic [1:0] op, input logic sub);
      logic [31:0] er;
      logic eco, eov, ez;
      an = a; bn = b; opn = op; sn = sub;
      #1;
      model({{(32-WN){1'b0}}, a}, {{(32-WN){1'b0}}, b}, op, sub, WN, er, eco, eov, ez);
      cmp(rtag(op, sub), {{(32-WN){1'b0}}, rn}, er);
      cmp("R8", {31'd0, con}, {31'd0, eco});
      cmp("R6", {31'd0, ovn}, {31'd0, eov});
      cmp("R7", {31'd0, zn}, {31'd0, ez});
   endtask

   // R1: AND on directed patterns
   task automatic test_and();
      apply32(32'h2376_AF0D, 32'h9A85_1BA3, 2'b00, 1'b0);
      apply32(32'hFFFF_FFFF, 32'h0000_0000, 2'b00, 1'b0);
      apply32(32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'b00, 1'b1);
   endtask

   // R2: OR on directed patterns
   task automatic test_or();
      apply32(32'h2376_AF0D, 32'h9A85_1BA3, 2'b01, 1'b0);
      apply32(32'h0000_0000, 32'h0000_0000, 2'b01, 1'b0);
      apply32(32'h8000_0000, 32'h0000_0001, 2'b01, 1'b1);
   endtask

   // R3, R8: addition including full carry ripple
   task automatic test_add();
      apply32(32'd5, 32'd35, 2'b10, 1'b0);
      apply32(32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 1'b0);
      apply32(32'h7FFF_FFFF, 32'h0000_0001, 2'b10, 1'b0);
      apply32(32'h8000_0000, 32'h8000_0000, 2'b10, 1'b0);
   endtask

   // R4, R7: subtraction, equal operands give zero
   task automatic test_sub();
      apply32(32'd40, 32'd5, 2'b10, 1'b1);
      apply32(32'd5, 32'd40, 2'b10, 1'b1);
      apply32(32'h1234_5678, 32'h1234_5678, 2'b10, 1'b1);
      apply32(32'h8000_0000, 32'h0000_0001, 2'b10, 1'b1);
   endtask

   // R5, R6: less-than including overflowing cases
   task automatic test_slt();
      apply32(32'd3, 32'd7, 2'b11, 1'b1);
      apply32(32'd7, 32'd3, 2'b11, 1'b1);
      apply32(32'hFFFF_FFFF, 32'd1, 2'b11, 1'b1);
      apply32(32'h8000_0000, 32'h0000_0001, 2'b11, 1'b1);
      apply32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b11, 1'b1);
      apply32(32'd9, 32'd9, 2'b11, 1'b1);
   endtask

   // R1..R8 on random 32-bit operands
   task automatic test_random();
      for (int k = 0; k < 400; k++) begin
         logic [2:0] f;
         f = 3'($urandom_range(0, 4));
         case (f)
            3'd0:    apply32($urandom, $urandom, 2'b00, 1'($urandom_range(0, 1)));
            3'd1:    apply32($urandom, $urandom, 2'b01, 1'($urandom_range(0, 1)));
            3'd2:    apply32($urandom, $urandom, 2'b10, 1'b0);
            3'd3:    apply32($urandom, $urandom, 2'b10, 1'b1);
            default: apply32($urandom, $urandom, 2'b11, 1'b1);
         endcase
      end
   endtask

   // R1..R8 exhaustively on the narrow build
   task automatic test_narrow();
      for (int a = 0; a < (1 << WN); a++) begin
         for (int b = 0; b < (1 << WN); b++) begin
            apply_n(WN'(a), WN'(b), 2'b00, 1'b0);
            apply_n(WN'(a), WN'(b), 2'b01, 1'b0);
            apply_n(WN'(a), WN'(b), 2'b10, 1'b0);
            apply_n(WN'(a), WN'(b), 2'b10, 1'b1);
            apply_n(WN'(a), WN'(b), 2'b11, 1'b1);
         end
      end
   endtask

   initial begin
      a32 = '0; b32 = '0; op32 = 2'b00; s32 = 1'b0;
      an = '0; bn = '0; opn = 2'b00; sn = 1'b0;
      // Idle state: zero operands under AND give a zero result and flag (R7)
      @(negedge clk);
      #1;
      cmp("R7", {31'd0, z32}, 32'd1);
      cmp("R1", r32, 32'd0);
      test_and();
      test_or();
      test_add();
      test_sub();
      test_slt();
      test_random();
      test_narrow();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule